// File: doc/BRIEF.md
# Windowed Bus Address Translator

This block sits between a CPU-side bus and a PCI-side bus and converts each outbound CPU address into the address the PCI unit should see. The four most significant address bits are thrown away. Bit 27 then decides where the access goes:
- When bit 27 is zero, the access falls in a 128 MB PCI aperture.
- When bit 27 is one, it belongs to the rest of the system space.

The PCI aperture is split into eight 16 MB windows. Bits 26:24 pick one of eight programmable 32-bit window offsets. Those three bits are removed from the address, and the chosen offset is added to the remaining 24-bit in-window address.

Software programs the offsets through a small write port that takes a window index and a value. After reset the offsets hold an identity map, so the aperture appears at 0x1000_0000 on the PCI side. Each translated access leaves on one of two output ports one clock after it is presented, and a valid flag travels with it. Accesses in the other direction, with the PCI side as master, go through a separate path. That path adds the same one-cycle delay and leaves the address unchanged.

Top module: `bus_window_xlat`

## Requirements
- R1: While rst_n is low at a clock edge, the output valids (pci_valid, sys_valid, ib_fwd_valid) are low on the next cycle. Window n is loaded with 0x1000_0000 + n*0x0100_0000.
- R2: An access with in_valid high and in_addr[27]=0 produces pci_valid high on the cycle after the edge that samples it, and sys_valid stays low.
- R3: The PCI address equals window[in_addr[26:24]] + in_addr[23:0]. For example, 0x1200_00FF with window 2 at reset produces 0x1200_00FF.
- R4: An access with in_addr[27]=1 produces sys_valid high one cycle later, with sys_addr = {4'h0, in_addr[27:0]}, and pci_valid stays low.
- R5: in_addr[31:28] has no effect on either output address.
- R6: When cfg_we is high at an edge, window cfg_idx is set to cfg_data. Other windows keep their values.
- R7: A window write and an access sampled at the same edge: the access uses the old offset. Any access sampled at a later edge uses the new one.
- R8: The window addition wraps modulo 2^32.
- R9: With in_valid low at an edge, pci_valid and sys_valid are low in the following cycle.
- R10: An inbound access (ib_valid) appears on ib_fwd_valid/ib_fwd_addr one cycle later with the address unchanged.
- R11: Accesses on consecutive cycles each produce their own result on consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Window register write strobe |
| cfg_idx | input | 3 | Window index to write |
| cfg_data | input | 32 | Window offset value to write |
| in_valid | input | 1 | Outbound CPU access valid |
| in_addr | input | 32 | Outbound CPU address |
| pci_valid | output | 1 | Translated access for the PCI aperture |
| pci_addr | output | 32 | Translated PCI address |
| sys_valid | output | 1 | Access for the rest of the system space |
| sys_addr | output | 32 | System address with top nibble cleared |
| ib_valid | input | 1 | Inbound access valid (PCI side as master) |
| ib_addr | input | 32 | Inbound address |
| ib_fwd_valid | output | 1 | Forwarded inbound access valid |
| ib_fwd_addr | output | 32 | Forwarded inbound address, untranslated |

## Verification
The hardest case to reach from the ports is a window write and an access that use the same window and are sampled on the same clock edge. Here the ordering rule decides whether the old offset or the new one is used. The bench drives the cfg write and the access in the same half-cycle and expects the old offset. It then sends a second access on the next cycle and expects the new offset. Wrap-around is reached by programming an offset near 2^32, and top-nibble independence is shown by repeating accesses with a garbage upper nibble.

// File: rtl/xlat_pkg.sv
// Shared constants and types for the windowed address translator.
// Assumes a 32-bit bus with eight 16 MB windows by default.
package xlat_pkg;
    localparam int unsigned XLAT_ADDR_W    = 32;
    localparam int unsigned XLAT_SPAN_W    = 24;
    localparam int unsigned XLAT_NUM_WIN   = 8;
    localparam logic [31:0] XLAT_IDENT_BASE = 32'h1000_0000;

    // Destination decoded from the select bit; the value is the bit itself.
    typedef enum logic {
        DEST_PCI = 1'b0,
        DEST_SYS = 1'b1
    } dest_e;
endpackage

// File: rtl/xlat_window_regs.sv
// Bank of window offset registers with one write port and one read port.
// Assumes writes and reads share a clock; a read returns the value held
// before any write on the same edge.
module xlat_window_regs #(
    parameter int unsigned ADDR_W   = 32,
    parameter int unsigned SPAN_W   = 24,
    parameter int unsigned NUM_WIN  = 8,
    parameter logic [ADDR_W-1:0] BASE = '0,
    localparam int unsigned IDX_W   = $clog2(NUM_WIN)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [ADDR_W-1:0] wr_val,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [ADDR_W-1:0] rd_val
);
    logic [ADDR_W-1:0] win_q [NUM_WIN];

    for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
        localparam logic [ADDR_W-1:0] RST_VAL =
            BASE + (ADDR_W'(w) << SPAN_W);
        // Hold one window offset; identity map on reset.
        always_ff @(posedge clk) begin
            if (!rst_n)
                win_q[w] <= RST_VAL;
            else if (wr_en && (wr_idx == IDX_W'(w)))
                win_q[w] <= wr_val;
        end
    end

    // Select the offset for the current access.
    always_comb begin
        rd_val = win_q[rd_idx];
    end
endmodule

// File: rtl/xlat_decode.sv
// Combinational decode of an outbound address: destination, window index,
// and both candidate output addresses. The top nibble is ignored.
module xlat_decode #(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned SPAN_W = 24,
    parameter int unsigned IDX_W  = 3,
    localparam int unsigned SEL_POS = SPAN_W + IDX_W
) (
    input  logic [ADDR_W-1:0]  addr,
    input  logic [ADDR_W-1:0]  win_off,
    output xlat_pkg::dest_e    dest,
    output logic [IDX_W-1:0]   win_idx,
    output logic [ADDR_W-1:0]  pci_nxt,
    output logic [ADDR_W-1:0]  sys_nxt
);
    // Split the address into select bit, window index and in-window offset.
    always_comb begin
        dest    = xlat_pkg::dest_e'(addr[SEL_POS]);
        win_idx = addr[SEL_POS-1:SPAN_W];
        pci_nxt = win_off + ADDR_W'(addr[SPAN_W-1:0]);
        sys_nxt = ADDR_W'(addr[SEL_POS:0]);
    end
endmodule

// File: rtl/xlat_out_stage.sv
// Output registers for both outbound ports and the inbound forward path.
// Assumes at most one access per cycle in each direction.
module xlat_out_stage #(
    parameter int unsigned ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  xlat_pkg::dest_e   req_dest,
    input  logic [ADDR_W-1:0] req_pci,
    input  logic [ADDR_W-1:0] req_sys,
    input  logic              ib_valid,
    input  logic [ADDR_W-1:0] ib_addr,
    output logic              pci_valid,
    output logic [ADDR_W-1:0] pci_addr,
    output logic              sys_valid,
    output logic [ADDR_W-1:0] sys_addr,
    output logic              ib_fwd_valid,
    output logic [ADDR_W-1:0] ib_fwd_addr
);
    // Register the valid flags by destination.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pci_valid    <= 1'b0;
            sys_valid    <= 1'b0;
            ib_fwd_valid <= 1'b0;
        end else begin
            pci_valid    <= req_valid && (req_dest == xlat_pkg::DEST_PCI);
            sys_valid    <= req_valid && (req_dest == xlat_pkg::DEST_SYS);
            ib_fwd_valid <= ib_valid;
        end
    end

    // Capture addresses only when an access lands on that port.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pci_addr    <= '0;
            sys_addr    <= '0;
            ib_fwd_addr <= '0;
        end else begin
            if (req_valid && (req_dest == xlat_pkg::DEST_PCI)) pci_addr <= req_pci;
            if (req_valid && (req_dest == xlat_pkg::DEST_SYS)) sys_addr <= req_sys;
            if (ib_valid) ib_fwd_addr <= ib_addr;
        end
    end
endmodule

// File: rtl/bus_window_xlat.sv
// Outbound address translator with eight programmable additive windows,
// plus an untranslated inbound forward path. One cycle of latency.
module bus_window_xlat #(
    parameter int unsigned ADDR_W  = xlat_pkg::XLAT_ADDR_W,
    parameter int unsigned SPAN_W  = xlat_pkg::XLAT_SPAN_W,
    parameter int unsigned NUM_WIN = xlat_pkg::XLAT_NUM_WIN,
    parameter logic [ADDR_W-1:0] BASE = xlat_pkg::XLAT_IDENT_BASE,
    localparam int unsigned IDX_W   = $clog2(NUM_WIN),
    localparam int unsigned SEL_POS = SPAN_W + IDX_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [IDX_W-1:0]  cfg_idx,
    input  logic [ADDR_W-1:0] cfg_data,
    input  logic              in_valid,
    input  logic [ADDR_W-1:0] in_addr,
    output logic              pci_valid,
    output logic [ADDR_W-1:0] pci_addr,
    output logic              sys_valid,
    output logic [ADDR_W-1:0] sys_addr,
    input  logic              ib_valid,
    input  logic [ADDR_W-1:0] ib_addr,
    output logic              ib_fwd_valid,
    output logic [ADDR_W-1:0] ib_fwd_addr
);
    xlat_pkg::dest_e   dest;
    logic [IDX_W-1:0]  win_idx;
    logic [ADDR_W-1:0] win_off;
    logic [ADDR_W-1:0] pci_nxt;
    logic [ADDR_W-1:0] sys_nxt;

    xlat_window_regs #(
        .ADDR_W(ADDR_W), .SPAN_W(SPAN_W), .NUM_WIN(NUM_WIN), .BASE(BASE)
    ) u_regs (
        .clk(clk), .rst_n(rst_n),
        .wr_en(cfg_we), .wr_idx(cfg_idx), .wr_val(cfg_data),
        .rd_idx(win_idx), .rd_val(win_off)
    );

    xlat_decode #(
        .ADDR_W(ADDR_W), .SPAN_W(SPAN_W), .IDX_W(IDX_W)
    ) u_dec (
        .addr(in_addr), .win_off(win_off), .dest(dest),
        .win_idx(win_idx), .pci_nxt(pci_nxt), .sys_nxt(sys_nxt)
    );

    xlat_out_stage #(.ADDR_W(ADDR_W)) u_out (
        .clk(clk), .rst_n(rst_n),
        .req_valid(in_valid), .req_dest(dest),
        .req_pci(pci_nxt), .req_sys(sys_nxt),
        .ib_valid(ib_valid), .ib_addr(ib_addr),
        .pci_valid(pci_valid), .pci_addr(pci_addr),
        .sys_valid(sys_valid), .sys_addr(sys_addr),
        .ib_fwd_valid(ib_fwd_valid), .ib_fwd_addr(ib_fwd_addr)
    );
endmodule

// File: rtl/xlat_chk.sv
// Port-level properties of the translator, attached by bind.
module xlat_chk #(
    parameter int unsigned ADDR_W  = 32,
    parameter int unsigned SEL_POS = 27
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [ADDR_W-1:0] in_addr,
    input logic              pci_valid,
    input logic              sys_valid,
    input logic [ADDR_W-1:0] sys_addr,
    input logic              ib_valid,
    input logic [ADDR_W-1:0] ib_addr,
    input logic              ib_fwd_valid,
    input logic [ADDR_W-1:0] ib_fwd_addr
);
    // R2
    pci_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_addr[SEL_POS]) |=> (pci_valid && !sys_valid));

    // R4
    sys_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_addr[SEL_POS]) |=>
            (sys_valid && !pci_valid &&
             sys_addr == ADDR_W'($past(in_addr[SEL_POS:0]))));

    // R9
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!pci_valid && !sys_valid));

    // R10
    inbound_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ib_valid |=> (ib_fwd_valid && ib_fwd_addr == $past(ib_addr)));

    // R2
    one_port_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({pci_valid, sys_valid}));
endmodule

bind bus_window_xlat xlat_chk #(.ADDR_W(ADDR_W), .SEL_POS(SEL_POS)) u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_addr(in_addr),
    .pci_valid(pci_valid), .sys_valid(sys_valid), .sys_addr(sys_addr),
    .ib_valid(ib_valid), .ib_addr(ib_addr),
    .ib_fwd_valid(ib_fwd_valid), .ib_fwd_addr(ib_fwd_addr)
);

// File: tb/bus_window_xlat_bench.sv
// Directed bench: one task per scenario, each checking its own results.
module bus_window_xlat_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_idx = '0;
    logic [31:0] cfg_data = '0;
    logic        in_valid = 1'b0;
    logic [31:0] in_addr = '0;
    logic        pci_valid, sys_valid, ib_fwd_valid;
    logic [31:0] pci_addr, sys_addr, ib_fwd_addr;
    logic        ib_valid = 1'b0;
    logic [31:0] ib_addr = '0;

    int n_vec = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    bus_window_xlat u_bus_window_xlat (
        .clk(clk), .rst_n(rst_n),
        .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_data(cfg_data),
        .in_valid(in_valid), .in_addr(in_addr),
        .pci_valid(pci_valid), .pci_addr(pci_addr),
        .sys_valid(sys_valid), .sys_addr(sys_addr),
        .ib_valid(ib_valid), .ib_addr(ib_addr),
        .ib_fwd_valid(ib_fwd_valid), .ib_fwd_addr(ib_fwd_addr)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Write one window at the next edge.
    task automatic wr_win(input logic [2:0] idx, input logic [31:0] val);
        @(negedge clk);
        cfg_we = 1'b1; cfg_idx = idx; cfg_data = val;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // Present one access and return what appears one cycle later.
    task automatic access(input logic [31:0] a, output logic pv, output logic [31:0] pa,
                          output logic sv, output logic [31:0] sa);
        @(negedge clk);
        in_valid = 1'b1; in_addr = a;
        @(negedge clk);
        in_valid = 1'b0;
        pv = pci_valid; pa = pci_addr; sv = sys_valid; sa = sys_addr;
    endtask

    task automatic t_reset();
        logic pv, sv; logic [31:0] pa, sa;
        chk("R1 pci_valid", {31'b0, pci_valid}, 32'd0);
        chk("R1 sys_valid", {31'b0, sys_valid}, 32'd0);
        chk("R1 ib_fwd_valid", {31'b0, ib_fwd_valid}, 32'd0);
        for (int n = 0; n < 8; n++) begin
            access(32'h1000_0123 | (n << 24), pv, pa, sv, sa);
            chk("R1 identity valid", {31'b0, pv}, 32'd1);
            chk("R1 identity addr", pa, 32'h1000_0123 + (n << 24));
        end
    endtask

    task automatic t_example();
        logic pv, sv; logic [31:0] pa, sa;
        access(32'h1200_00FF, pv, pa, sv, sa);
        chk("R2 pci_valid", {31'b0, pv}, 32'd1);
        chk("R2 sys_valid low", {31'b0, sv}, 32'd0);
        chk("R3 worked example", pa, 32'h1200_00FF);
    endtask

    task automatic t_program();
        logic pv, sv; logic [31:0] pa, sa;
        wr_win(3'd5, 32'h4000_0000);
        access(32'h0500_0010, pv, pa, sv, sa);
        chk("R6 new window 5", pa, 32'h4000_0010);
        access(32'hF5AB_CDEF, pv, pa, sv, sa);
        chk("R5 top nibble ignored pci", pa, 32'h40AB_CDEF);
        access(32'h0400_0010, pv, pa, sv, sa);
        chk("R6 window 4 untouched", pa, 32'h1400_0010);
        access(32'h0701_0203, pv, pa, sv, sa);
        chk("R3 window 7 add", pa, 32'h1701_0203);
    endtask

    task automatic t_wrap();
        logic pv, sv; logic [31:0] pa, sa;
        wr_win(3'd3, 32'hFFFF_FF00);
        access(32'h0300_01FF, pv, pa, sv, sa);
        chk("R8 wrap", pa, 32'h0000_00FF);
    endtask

    task automatic t_sys();
        logic pv, sv; logic [31:0] pa, sa;
        access(32'h1800_1234, pv, pa, sv, sa);
        chk("R4 sys_valid", {31'b0, sv}, 32'd1);
        chk("R4 pci_valid low", {31'b0, pv}, 32'd0);
        chk("R4 sys_addr", sa, 32'h0800_1234);
        access(32'hAFED_CBA9, pv, pa, sv, sa);
        chk("R5 top nibble ignored sys", sa, 32'h0FED_CBA9);
    endtask

    task automatic t_idle();
        @(negedge clk);
        in_valid = 1'b0; in_addr = 32'h1200_0000;
        @(negedge clk);
        chk("R9 pci idle", {31'b0, pci_valid}, 32'd0);
        chk("R9 sys idle", {31'b0, sys_valid}, 32'd0);
    endtask

    task automatic t_same_edge();
        @(negedge clk);
        cfg_we = 1'b1; cfg_idx = 3'd6; cfg_data = 32'h2000_0000;
        in_valid = 1'b1; in_addr = 32'h0600_0004;
        @(negedge clk);
        cfg_we = 1'b0;
        chk("R7 same edge old offset", pci_addr, 32'h1600_0004);
        in_addr = 32'h0600_0008;
        @(negedge clk);
        in_valid = 1'b0;
        chk("R7 next access new offset", pci_addr, 32'h2000_0008);
    endtask

    task automatic t_burst();
        @(negedge clk);
        in_valid = 1'b1; in_addr = 32'h1100_0001;
        @(negedge clk);
        chk("R11 burst first", pci_addr, 32'h1100_0001);
        in_addr = 32'h1900_0002;
        @(negedge clk);
        chk("R11 burst second sys", {sys_valid, sys_addr[30:0]}, {1'b1, 31'h0900_0002});
        chk("R11 burst second pci low", {31'b0, pci_valid}, 32'd0);
        in_addr = 32'h1200_0003;
        @(negedge clk);
        in_valid = 1'b0;
        chk("R11 burst third", {pci_valid, pci_addr[30:0]}, {1'b1, 31'h1200_0003});
    endtask

    task automatic t_inbound();
        @(negedge clk);
        ib_valid = 1'b1; ib_addr = 32'hDEAD_BEEF;
        @(negedge clk);
        ib_valid = 1'b0;
        chk("R10 ib valid", {31'b0, ib_fwd_valid}, 32'd1);
        chk("R10 ib addr", ib_fwd_addr, 32'hDEAD_BEEF);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_example();
        t_program();
        t_wrap();
        t_sys();
        t_idle();
        t_same_edge();
        t_burst();
        t_inbound();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        n_vec++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule